// File: doc/BRIEF.md
# Master Clock Ratio Detector with 256fs Enable

This block sits in the master clock domain of an audio converter and lets everything downstream act as if the master clock were always 256 times the sample rate. It watches the frame clock, which runs at the sample rate fs, and counts master clock cycles between its rising edges to tell a 256fs master clock from a 384fs one. Once the same valid ratio has been measured on two frames in a row, it declares lock. It then issues a clock-enable strobe that fires on 256 master cycles per frame. At 256fs the strobe fires on every cycle. At 384fs it fires on two cycles out of every three.

The master clock and frame clock share a frequency but not a known phase, so the frame clock is brought in through a two-flop synchronizer and only its detected rising edge is used. An active-low power-down input clears all state. After release, timing restarts from the next frame edge seen in the master domain. A frame period that matches neither ratio, or a frame clock that stops, removes lock and silences the strobe until a valid ratio has repeated.

Top module: `mclk_ratio_div`

## Requirements
- R1: While `rst_n` is low, `locked`, `clk_en` and `mode_384` are all 0, and all measurement state is cleared asynchronously.
- R2: A period of 256 master cycles between frame clock rising edges selects bypass (`mode_384`=0). A period of 384 selects two-thirds mode (`mode_384`=1).
- R3: The first frame rising edge after reset only starts a measurement. `locked` rises only at the edge that completes the second of two consecutive periods of the same valid ratio, so at least three rising edges are needed.
- R4: `clk_en` is 0 in every cycle in which `locked` is 0.
- R5: While locked in bypass, `clk_en` is 1 on every master cycle (256 per frame).
- R6: While locked in two-thirds mode, `clk_en` is 1 on exactly two of every three master cycles. There are never three enabled cycles in a row and never two disabled cycles in a row, giving 256 enables per 384-cycle frame.
- R7: In two-thirds mode the pattern restarts at each detected frame edge. If the frame clock goes high just after master edge k, the edge is detected in the cycle after master edge k+2. That cycle and the next are enabled, the one after is disabled, and the cycle before detection is disabled.
- R8: A period that is neither 256 nor 384 drops `locked` at the edge that ends it. Re-locking needs two consecutive equal valid periods.
- R9: If no frame rising edge arrives for 2^CNT_W-1 master cycles (1023 by default), `locked` drops and the next period is treated as invalid.
- R10: While `locked` stays high, `mode_384` does not change. A change of ratio always passes through at least one unlocked cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock (256fs or 384fs) |
| rst_n | input | 1 | Active-low power-down / asynchronous reset |
| frame_clk | input | 1 | Frame clock at fs, asynchronous in phase |
| clk_en | output | 1 | Enable strobe marking the internal 256fs rate |
| locked | output | 1 | Ratio has been confirmed on two consecutive frames |
| mode_384 | output | 1 | 1 when the confirmed ratio is 384fs, 0 for 256fs |

## Verification
The bench goes after the lock threshold right after reset. A design that locks on a single measured period would show `locked` high after only two frames.

It checks the enable phase at the frame edge. A divider that free-runs, or that restarts on the wrong cycle, would break the 0,1,1,0 samples around detection.

It checks switching between ratios, alternating ratios, an invalid period and a stalled frame clock. Any of these that failed to drop lock would keep strobing at a wrong rate or report a stale mode.

Asynchronous reset in the middle of a locked run is also covered. It must silence the outputs at once and force a full re-measurement.

// File: rtl/mclk_ratio_div.sv
module mclk_ratio_div #(
  parameter int CNT_W    = 10,
  parameter int LO_RATIO = 256,
  parameter int HI_RATIO = 384
) (
  input  logic mclk,
  input  logic rst_n,
  input  logic frame_clk,
  output logic clk_en,
  output logic locked,
  output logic mode_384
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LO_LAST = CNT_W'(LO_RATIO - 1);
  localparam logic [CNT_W-1:0] HI_LAST = CNT_W'(HI_RATIO - 1);
  localparam logic [1:0] C_NONE = 2'd0, C_LO = 2'd1, C_HI = 2'd2;

  logic [2:0]       fs;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       ph;
  logic [1:0]       prev_cls;
  logic             started;
  logic             rise;
  logic [1:0]       cls;
  logic [1:0]       ph_eff;

  assign rise   = fs[1] & ~fs[2];
  assign cls    = (cnt == LO_LAST) ? C_LO : (cnt == HI_LAST) ? C_HI : C_NONE;
  assign ph_eff = rise ? 2'd0 : ph;
  assign clk_en = locked & (~mode_384 | (ph_eff != 2'd2));

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      fs       <= '0;
      cnt      <= '0;
      ph       <= '0;
      prev_cls <= C_NONE;
      started  <= 1'b0;
      locked   <= 1'b0;
      mode_384 <= 1'b0;
    end else begin
      fs <= {fs[1:0], frame_clk};
      ph <= (ph_eff == 2'd2) ? 2'd0 : ph_eff + 2'd1;
      if (rise)
        cnt <= '0;
      else if (cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
      if (rise) begin
        if (!started) begin
          started <= 1'b1;
        end else begin
          prev_cls <= cls;
          if (cls != C_NONE && cls == prev_cls) begin
            locked   <= 1'b1;
            mode_384 <= (cls == C_HI);
          end else begin
            locked <= 1'b0;
          end
        end
      end else if (cnt == CNT_MAX) begin
        locked   <= 1'b0;
        prev_cls <= C_NONE;
      end
    end
  end

endmodule

module mclk_ratio_div_chk (
  input logic mclk,
  input logic rst_n,
  input logic frame_clk,
  input logic clk_en,
  input logic locked,
  input logic mode_384
);

  AST_RESET_QUIET: assert property (@(posedge mclk)
    !rst_n |-> (!locked && !clk_en && !mode_384)); // R1

  AST_EN_NEEDS_LOCK: assert property (@(posedge mclk) disable iff (!rst_n)
    !locked |-> !clk_en); // R4

  AST_BYPASS_EVERY_CYCLE: assert property (@(posedge mclk) disable iff (!rst_n)
    (locked && !mode_384) |-> clk_en); // R5

  AST_NO_THREE_RUN: assert property (@(posedge mclk) disable iff (!rst_n)
    (locked && mode_384 && clk_en && $past(clk_en)) |=> !clk_en); // R6

  AST_NO_TWO_GAPS: assert property (@(posedge mclk) disable iff (!rst_n)
    (locked && mode_384 && !clk_en) |=> (clk_en || !locked)); // R6

  AST_MODE_HELD: assert property (@(posedge mclk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(mode_384)); // R10

endmodule

bind mclk_ratio_div mclk_ratio_div_chk u_chk (.*);

// File: tb/test_mclk_ratio_div.sv
`timescale 1ns/1ps
module test_mclk_ratio_div;

  logic mclk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic clk_en, locked, mode_384;

  always #2.5 mclk = ~mclk;

  mclk_ratio_div i_mclk_ratio_div (
    .mclk(mclk), .rst_n(rst_n), .frame_clk(frame_clk),
    .clk_en(clk_en), .locked(locked), .mode_384(mode_384)
  );

  int errors = 0;
  int checks = 0;
  int g_en;
  bit g_saw_lock, g_saw_unlock;
  bit g_pat [6];
  bit done = 1'b0;

  // period, expected lock, expected mode, expected enables, expect a drop
  localparam int NV = 5;
  localparam int V_PER  [NV] = '{256, 384, 300, 384, 256};
  localparam int V_LOCK [NV] = '{1,   1,   0,   1,   1};
  localparam int V_MODE [NV] = '{0,   1,   0,   1,   0};
  localparam int V_EN   [NV] = '{256, 256, 0,   256, 256};
  localparam int V_DROP [NV] = '{0,   1,   1,   1,   1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_obs();
    g_en = 0; g_saw_lock = 0; g_saw_unlock = 0;
    for (int k = 0; k < 6; k++) g_pat[k] = 0;
  endtask

  task automatic run_frame(input int period);
    for (int i = 0; i < period; i++) begin
      @(negedge mclk);
      g_en += int'(clk_en);
      if (locked) g_saw_lock = 1; else g_saw_unlock = 1;
      if (i < 6) g_pat[i] = clk_en;
      frame_clk = (i < period / 2);
    end
  endtask

  task automatic run_frames(input int period, input int n);
    for (int f = 0; f < n; f++) run_frame(period);
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge mclk);
      wd++;
      if (wd > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge mclk);
    check(!locked && !clk_en && !mode_384, "R1 reset outputs", {locked, clk_en, mode_384}, 0);
    rst_n = 1'b1;

    // R3: two frames are not enough, the third edge locks
    clear_obs();
    run_frames(256, 2);
    check(!g_saw_lock, "R3 no lock after two edges", g_saw_lock, 0);
    run_frames(256, 1);
    run_frame(256);
    check(locked == 1'b1, "R3 lock after third edge", locked, 1);
    check(mode_384 == 1'b0, "R2 bypass mode at 256", mode_384, 0);

    for (int v = 0; v < NV; v++) begin
      clear_obs();
      run_frames(V_PER[v], 4);
      check(g_saw_unlock == V_DROP[v], "R8 R10 lock drop on change", g_saw_unlock, V_DROP[v]);
      clear_obs();
      run_frame(V_PER[v]);
      check(locked == V_LOCK[v], "R2 R8 lock state", locked, V_LOCK[v]);
      if (V_LOCK[v] == 1)
        check(mode_384 == V_MODE[v], "R2 detected ratio", mode_384, V_MODE[v]);
      check(g_en == V_EN[v], "R4 R5 R6 enables per frame", g_en, V_EN[v]);
      if (V_PER[v] == 384) begin
        check({g_pat[1], g_pat[2], g_pat[3], g_pat[4]} == 4'b0110,
              "R7 phase at frame edge", {g_pat[1], g_pat[2], g_pat[3], g_pat[4]}, 4'b0110);
      end
    end

    // R8: alternating ratios never lock
    for (int k = 0; k < 2; k++) begin run_frame(256); run_frame(384); end
    clear_obs();
    for (int k = 0; k < 2; k++) begin run_frame(256); run_frame(384); end
    check(!g_saw_lock && g_en == 0, "R8 alternating ratios stay unlocked", g_en, 0);

    // R9: stalled frame clock drops lock
    run_frames(384, 4);
    check(locked && mode_384, "R2 relock at 384", locked, 1);
    for (int i = 0; i < 1100; i++) @(negedge mclk);
    check(!locked && !clk_en, "R9 stall drops lock", locked, 0);
    clear_obs();
    run_frames(384, 2);
    check(!g_saw_lock, "R9 stalled period invalid", g_saw_lock, 0);
    run_frames(384, 2);
    check(locked == 1'b1, "R9 relock after stall", locked, 1);

    // R1: asynchronous reset while locked
    run_frame(384);
    @(negedge mclk);
    rst_n = 1'b0;
    #1;
    check(!locked && !clk_en && !mode_384, "R1 async reset clears", {locked, clk_en, mode_384}, 0);
    frame_clk = 1'b0;
    repeat (3) @(negedge mclk);
    rst_n = 1'b1;
    clear_obs();
    run_frames(384, 2);
    check(!g_saw_lock && g_en == 0, "R3 relearn after reset", g_saw_lock, 0);
    run_frames(384, 2);
    check(locked && mode_384, "R3 lock after reset", locked, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule